// File: doc/BRIEF.md
# Table-Driven Shaped I/Q Modulator

This block produces transmit I/Q samples that are already root-raised-cosine shaped, at eight samples per symbol. It does not run a multiply-accumulate filter. Each rail keeps a short register of recent symbol bits. That history, joined to a sample-phase counter, addresses a table of precomputed filter outputs. The table entries already carry both the pulse shape and the transmit power scaling, so the output needs no further arithmetic.

There is one bank of tables for each constellation: QPSK, 16-QAM and 64-QAM. Each bank has an I table and a Q table of 64 entries each. The active bank follows a mode selector. A processor loads or retunes the tables through a simple address/data/write-enable port, which lets shaping and scaling change without touching the logic.

Symbols arrive on a valid/ready handshake, one per eight output samples. A missing symbol is replaced by an all-zero symbol.

Top module: `shaped_symbol_mod`

## Requirements
- R1: After reset, out_valid, out_i, out_q and sym_ready are zero, every table entry reads zero, and the active constellation is QPSK.
- R2: While tx_en is high, sym_ready is high for exactly one cycle in every eight. The sample phase runs 7 (on the first enabled cycle) then 0,1,...,7 repeatedly, and sym_ready is high in the cycles where the phase is 7.
- R3: In a cycle with tx_en high, the following cycle drives out_i and out_q with the entries of the active bank's I and Q tables at address {history, phase}. The 3-bit history forms the upper address bits and the 3-bit phase forms the lower bits. out_valid is 1 in that following cycle.
- R4: On each symbol acceptance, every rail history is shifted left by the constellation's bits per rail, and that many low bits of sym_i or sym_q are inserted at the bottom. Only the low 3 bits are kept. The bits per rail are 1 for QPSK (mode_sel 0), 2 for 16-QAM (mode_sel 1) and 3 for 64-QAM (mode_sel 2).
- R5: If sym_valid is low in a cycle where sym_ready is high, a symbol with all-zero bits is shifted in instead.
- R6: While tx_en is high, a change of mode_sel takes effect only at the next symbol acceptance. At that acceptance, the older history bits are cleared, so the history holds only the new symbol's bits.
- R7: A table write (wr_bank 0..2 select the bank, wr_rail 0 is I and 1 is Q, wr_addr selects the entry) is stored one cycle later. A write to the active bank while tx_en is high is dropped, and wr_bank 3 is always dropped.
- R8: While tx_en is low, the outputs of the next cycle are zero, the history is cleared, the phase is set to 7, and the active constellation follows mode_sel directly.
- R9: mode_sel value 3 is ignored, and the active constellation keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| mode_sel | input | 2 | Requested constellation (0 QPSK, 1 16-QAM, 2 64-QAM) |
| sym_valid | input | 1 | Symbol present |
| sym_ready | output | 1 | Symbol taken at this edge |
| sym_i | input | 3 | I rail symbol bits (low bits used) |
| sym_q | input | 3 | Q rail symbol bits (low bits used) |
| wr_en | input | 1 | Table write strobe |
| wr_bank | input | 2 | Bank to write |
| wr_rail | input | 1 | Rail to write (0 I, 1 Q) |
| wr_addr | input | 6 | Table entry to write |
| wr_data | input | 10 | Value to write |
| out_valid | output | 1 | Sample valid |
| out_i | output | 10 | Shaped I sample |
| out_q | output | 10 | Shaped Q sample |

## Verification
The hardest case to reach is a bank switch that lands on a symbol boundary while both the history and the table contents are in flux. A mode request has to sit pending for several phases before it is applied. In the same window, writes aimed at the active bank must be dropped and writes to an idle bank must land. The stimulus changes mode_sel in the middle of a symbol during a continuous random symbol stream, with random sym_valid gaps. It issues writes to both the active and an idle bank during transmission, and later switches to the written bank so that the stored value shows up at out_i/out_q. A behavioural model compares every sample on every clock.

// File: rtl/shaped_mod_pkg.sv
package shaped_mod_pkg;
  typedef enum logic [1:0] {
    MOD_QPSK  = 2'd0,
    MOD_QAM16 = 2'd1,
    MOD_QAM64 = 2'd2
  } mod_e;

  localparam int unsigned NUM_BANKS = 3;

  // bits carried per rail per symbol for each constellation
  function automatic int unsigned rail_bits(mod_e m);
    case (m)
      MOD_QPSK:  return 1;
      MOD_QAM16: return 2;
      default:   return 3;
    endcase
  endfunction
endpackage

// File: rtl/tap_table.sv
module tap_table #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 10,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/symbol_sequencer.sv
module symbol_sequencer
  import shaped_mod_pkg::*;
#(
  parameter int unsigned SPS  = 8,
  parameter int unsigned HW   = 3,
  parameter int unsigned MB   = 3,
  localparam int unsigned PH_W = $clog2(SPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_en,
  input  logic [1:0]      mode_sel,
  input  logic            sym_valid,
  input  logic [MB-1:0]   sym_i,
  input  logic [MB-1:0]   sym_q,
  output logic            sym_take,
  output logic [PH_W-1:0] phase,
  output logic [HW-1:0]   hist_i,
  output logic [HW-1:0]   hist_q,
  output mod_e            active_mode
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(SPS - 1);

  logic [PH_W-1:0] phase_q;
  logic [HW-1:0]   hist_i_q, hist_q_q;
  mod_e            mode_q;

  // history update: shift by b bits, insert masked symbol, optional clear
  function automatic logic [HW-1:0] push_hist(logic [HW-1:0] h, logic [MB-1:0] s,
                                               int unsigned b, logic clr);
    logic [HW+MB-1:0] w;
    logic [MB-1:0]    m;
    m = MB'((1 << b) - 1);
    w = clr ? '0 : ({{MB{1'b0}}, h} << b);
    w = w | {{HW{1'b0}}, s & m};
    return w[HW-1:0];
  endfunction

  wire  boundary   = tx_en && (phase_q == LAST_PH);
  wire  sel_legal  = (mode_sel != 2'd3);
  wire  switch_now = sel_legal && (mod_e'(mode_sel) != mode_q);
  mod_e next_mode;
  logic [MB-1:0] in_i, in_q;

  always_comb begin
    next_mode = switch_now ? mod_e'(mode_sel) : mode_q;
    in_i      = sym_valid ? sym_i : '0;
    in_q      = sym_valid ? sym_q : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= LAST_PH;
      hist_i_q <= '0;
      hist_q_q <= '0;
      mode_q   <= MOD_QPSK;
    end else if (!tx_en) begin
      phase_q  <= LAST_PH;
      hist_i_q <= '0;
      hist_q_q <= '0;
      if (sel_legal) mode_q <= mod_e'(mode_sel);
    end else if (boundary) begin
      phase_q  <= '0;
      mode_q   <= next_mode;
      hist_i_q <= push_hist(hist_i_q, in_i, rail_bits(next_mode), switch_now);
      hist_q_q <= push_hist(hist_q_q, in_q, rail_bits(next_mode), switch_now);
    end else begin
      phase_q  <= phase_q + 1'b1;
    end
  end

  assign sym_take    = boundary;
  assign phase       = phase_q;
  assign hist_i      = hist_i_q;
  assign hist_q      = hist_q_q;
  assign active_mode = mode_q;

  p_ready_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_take |=> !sym_take);
  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_take && tx_en |=> phase_q == '0);
  p_underrun_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sym_take && !sym_valid |=> hist_i_q[0] == 1'b0 && hist_q_q[0] == 1'b0);
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && $past(tx_en) && !$past(sym_take) |-> $stable(mode_q));
  p_bad_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'd3 |=> $stable(mode_q));
endmodule

// File: rtl/shaped_symbol_mod.sv
module shaped_symbol_mod
  import shaped_mod_pkg::*;
#(
  parameter int unsigned SPS   = 8,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 10,
  parameter int unsigned MB    = 3,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PH_W = $clog2(SPS),
  localparam int unsigned HW   = AW - PH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic [1:0]    mode_sel,
  input  logic          sym_valid,
  output logic          sym_ready,
  input  logic [MB-1:0] sym_i,
  input  logic [MB-1:0] sym_q,
  input  logic          wr_en,
  input  logic [1:0]    wr_bank,
  input  logic          wr_rail,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          out_valid,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q
);
  logic [PH_W-1:0] phase;
  logic [HW-1:0]   hist_i, hist_q;
  mod_e            active_mode;
  logic            sym_take;

  symbol_sequencer #(.SPS(SPS), .HW(HW), .MB(MB)) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mode_sel(mode_sel),
    .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
    .sym_take(sym_take), .phase(phase), .hist_i(hist_i), .hist_q(hist_q),
    .active_mode(active_mode)
  );

  // a write is dropped when it targets the bank being played out
  wire wr_block = (wr_bank == 2'd3) || (tx_en && (wr_bank == 2'(active_mode)));

  logic [DW-1:0] rd [NUM_BANKS][2];
  wire  [AW-1:0] addr_i = {hist_i, phase};
  wire  [AW-1:0] addr_q = {hist_q, phase};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar r = 0; r < 2; r++) begin : g_rail
      wire we = wr_en && !wr_block && (wr_bank == 2'(b)) && (wr_rail == 1'(r));
      tap_table #(.DEPTH(DEPTH), .DW(DW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(wr_addr), .wdata(wr_data),
        .raddr((r == 0) ? addr_i : addr_q), .rdata(rd[b][r])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= tx_en;
      out_i     <= tx_en ? rd[active_mode][0] : '0;
      out_q     <= tx_en ? rd[active_mode][1] : '0;
    end
  end

  assign sym_ready = sym_take;

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !out_valid && out_i == '0 && out_q == '0);
  p_valid_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> out_valid);
  p_ready_needs_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_ready |-> tx_en);
endmodule

// File: tb/shaped_symbol_mod_test.sv
`timescale 1ns/1ps
module shaped_symbol_mod_test;
  logic clk = 0, rst_n = 0, tx_en = 0, sym_valid = 0, wr_en = 0, wr_rail = 0;
  logic [1:0] mode_sel = 0, wr_bank = 0;
  logic [2:0] sym_i = 0, sym_q = 0;
  logic [5:0] wr_addr = 0;
  logic [9:0] wr_data = 0;
  logic sym_ready, out_valid;
  logic [9:0] out_i, out_q;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  shaped_symbol_mod uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mode_sel(mode_sel),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_i(sym_i), .sym_q(sym_q),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_rail(wr_rail), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  // behavioural reference
  int tbl [3][2][64];
  int m_phase = 7, m_hi = 0, m_hq = 0, m_mode = 0;
  int e_valid = 0, e_i = 0, e_q = 0;

  function automatic int nbits(int m);
    return m + 1;
  endfunction

  always @(posedge clk) begin
    int old_mode, si, sq, b;
    if (!rst_n) begin
      foreach (tbl[x, y, z]) tbl[x][y][z] = 0;
      m_phase = 7; m_hi = 0; m_hq = 0; m_mode = 0;
      e_valid = 0; e_i = 0; e_q = 0;
    end else begin
      old_mode = m_mode;
      if (!tx_en) begin
        e_valid = 0; e_i = 0; e_q = 0;
        m_phase = 7; m_hi = 0; m_hq = 0;
        if (mode_sel != 3) m_mode = mode_sel;
      end else begin
        e_valid = 1;
        e_i = tbl[m_mode][0][m_hi * 8 + m_phase];
        e_q = tbl[m_mode][1][m_hq * 8 + m_phase];
        if (m_phase == 7) begin
          si = sym_valid ? sym_i : 0;
          sq = sym_valid ? sym_q : 0;
          if (mode_sel != 3 && mode_sel != m_mode) begin
            m_mode = mode_sel; m_hi = 0; m_hq = 0;
          end
          b = nbits(m_mode);
          m_hi = ((m_hi << b) | (si & ((1 << b) - 1))) & 7;
          m_hq = ((m_hq << b) | (sq & ((1 << b) - 1))) & 7;
          m_phase = 0;
        end else m_phase++;
      end
      if (wr_en && wr_bank != 3 && !(tx_en && wr_bank == old_mode))
        tbl[wr_bank][wr_rail][wr_addr] = wr_data;
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  // advance one clock and compare all outputs with the model
  task automatic tick();
    int er;
    @(posedge clk); #2;
    er = (tx_en && m_phase == 7) ? 1 : 0;
    chk(out_valid == e_valid, "out_valid", out_valid, e_valid);
    chk(out_i == 10'(e_i), "out_i", out_i, e_i);
    chk(out_q == 10'(e_q), "out_q", out_q, e_q);
    chk(sym_ready == er[0], "sym_ready", sym_ready, er);
  endtask

  task automatic stream(int n, int valid_pct);
    for (int k = 0; k < n; k++) begin
      sym_valid = ($urandom % 100) < valid_pct;
      sym_i = 3'($urandom); sym_q = 3'($urandom);
      tick();
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int pulses;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cur_req = "R1";
    tick();
    chk(out_valid == 0 && out_i == 0 && sym_ready == 0, "R1 reset outputs", out_i, 0);

    // R7 / R8: load every table while idle; outputs stay zero
    cur_req = "R7 R8";
    for (int b = 0; b < 3; b++)
      for (int r = 0; r < 2; r++)
        for (int a = 0; a < 64; a++) begin
          wr_en = 1; wr_bank = 2'(b); wr_rail = 1'(r); wr_addr = 6'(a);
          wr_data = 10'((b * 197 + r * 89 + a * 29 + 5) & 1023);
          mode_sel = 2'(b);
          tick();
        end
    wr_en = 0; mode_sel = 0;
    tick();

    // R3 R4 QPSK stream
    cur_req = "R3 R4 QPSK";
    tx_en = 1;
    stream(120, 100);

    // R2 ready cadence
    cur_req = "R2";
    pulses = 0;
    for (int k = 0; k < 80; k++) begin
      sym_valid = 1; sym_i = 3'($urandom); sym_q = 3'($urandom);
      tick();
      if (sym_ready) pulses++;
    end
    chk(pulses == 10, "R2 ready pulses in 80 cycles", pulses, 10);

    // R4 16-QAM selected while idle
    cur_req = "R4 R8 16QAM";
    tx_en = 0; mode_sel = 1; tick(); tick();
    tx_en = 1;
    stream(120, 100);

    // R6 mid-symbol switch to 64-QAM
    cur_req = "R6";
    stream(3, 100);
    mode_sel = 2;
    stream(120, 100);

    // R5 underrun gaps
    cur_req = "R5";
    stream(200, 40);
    sym_valid = 0;
    stream(40, 0);

    // R7 writes during transmit: active bank (2) dropped, idle bank (0) taken
    cur_req = "R7";
    for (int a = 0; a < 64; a++) begin
      wr_en = 1; wr_bank = 2; wr_rail = 1'(a & 1); wr_addr = 6'(a); wr_data = 10'h3FF;
      sym_valid = 1; sym_i = 3'($urandom); sym_q = 3'($urandom);
      tick();
    end
    for (int a = 0; a < 64; a++) begin
      wr_en = 1; wr_bank = 0; wr_rail = 1'(a & 1); wr_addr = 6'(a); wr_data = 10'(a * 7 + 300);
      tick();
    end
    wr_en = 1; wr_bank = 3; wr_addr = 0; wr_data = 10'h155; tick();
    wr_en = 0;
    stream(64, 100);
    mode_sel = 0;
    stream(100, 100);

    // R9 illegal selector
    cur_req = "R9";
    mode_sel = 3;
    stream(60, 100);
    tx_en = 0; tick(); tick();
    tx_en = 1;
    stream(40, 90);

    // R8 disable mid-run
    cur_req = "R8";
    stream(5, 100);
    tx_en = 0;
    stream(6, 100);
    chk(out_valid == 0 && out_i == 0 && out_q == 0, "R8 idle outputs", out_i, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule